// File: doc/BRIEF.md
# Interleaved Bank Sweep Data Mover

This block moves a multiword operand from one memory bank to another by driving block-memory addresses word by word. Each bank holds two parallel sub-banks, X and Y, that share one address and one write enable, so any write stores an X word and a Y word together. A single shared read port returns the X and Y words of the addressed location one cycle after the read is issued.

One state machine serves every opcode. For each word index it spends one cycle reading the source location and one cycle on a destination slot. When only one sub-bank is to be replaced, the destination slot reads the current destination word so that the sub-bank being kept can be written back with its own value. When both sub-banks are replaced, the destination read is suppressed but the slot is still spent, so every opcode takes the same number of cycles. Read data is registered before the X/Y pair is formed, and the pair is written one word per two cycles. A one-cycle done pulse follows the final write.

Top module: `bank_sweep_mover`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows rd_en, wr_en, done and busy all low, and no sweep in progress continues.
- R2: Opcode 0 (copy both) with N words writes, for each index i below N, destination X and Y with source X and Y at index i; every other location is left unchanged.
- R3: Opcode 1 (replace X only) writes destination X with source X for indices below N and leaves destination Y bit-identical to its prior contents; every other location is unchanged.
- R4: Opcode 2 (replace Y only) writes destination Y with source Y for indices below N and leaves destination X bit-identical; every other location is unchanged.
- R5: Each word uses a source-read slot followed by a destination slot, so writes are never in consecutive cycles; a sweep issues N reads for opcode 0 and 2N reads for opcodes 1 and 2. Addresses are {bank, index} with the bank in the upper bits.
- R6: A sweep performs exactly N writes, one per index, in ascending index order, each to the destination bank.
- R7: done is high for exactly one cycle, the cycle after the final write, which is 2N+3 cycles after the clock edge that accepted start.
- R8: A start raised while busy is high is ignored and does not change the running sweep or its results.
- R9: A start with word count 0, a count above the bank depth, or opcode 3 is ignored: no read, no write, no done, busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| opcode | input | 2 | 0 copy both, 1 replace X only, 2 replace Y only, 3 reserved |
| src_bank | input | BANK_W | Source bank select |
| dst_bank | input | BANK_W | Destination bank select |
| word_cnt | input | IDX_W+1 | Number of words to move |
| rd_addr | output | BANK_W+IDX_W | Read address {bank, index} |
| rd_en | output | 1 | Read enable |
| rd_x | input | WORD_W | X read data, valid one cycle after rd_en |
| rd_y | input | WORD_W | Y read data, valid one cycle after rd_en |
| wr_addr | output | BANK_W+IDX_W | Write address {bank, index} |
| wr_x | output | WORD_W | X write data |
| wr_y | output | WORD_W | Y write data |
| wr_en | output | 1 | Joint write enable for X and Y |
| busy | output | 1 | Sweep or write pipeline active |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The assertions assume start is a clean synchronous level and that rst_n is held low for at least one clock edge at time zero, so the outputs are defined before any property is evaluated. They also take for granted that the memory returns read data exactly one cycle after rd_en; the bench model honours this by registering the addressed X and Y words on the enabling edge. Stimulus is driven on falling edges and refills every bank with a distinct pattern before each sweep, so a stale or swapped word cannot match by accident.

// File: rtl/mover_pkg.sv
// Shared types for the bank sweep mover.
// Assumes: two-bit opcode field; value 3 is reserved and rejected.
package mover_pkg;
    typedef enum logic [1:0] {
        OP_COPY_XY = 2'd0,
        OP_COPY_X  = 2'd1,
        OP_COPY_Y  = 2'd2,
        OP_RSVD    = 2'd3
    } mv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SRC_SLOT = 2'd1,
        ST_DST_SLOT = 2'd2
    } mv_state_e;
endpackage

// File: rtl/sweep_ctrl.sv
// Sweep controller: accepts a start, then alternates a source-read slot and
// a destination slot for each word index, driving the shared read port.
// Assumes: pipe_busy is high while earlier words are still being written.
module sweep_ctrl
    import mover_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int BANK_W = 2,
    localparam int CNT_W  = IDX_W + 1,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_in,
    input  logic [BANK_W-1:0] src_in,
    input  logic [BANK_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              pipe_busy,
    output mv_state_e         state,
    output logic [IDX_W-1:0]  idx,
    output logic              last_word,
    output mv_op_e            op_q,
    output logic [BANK_W-1:0] dst_q,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en
);
    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1 << IDX_W);

    logic [BANK_W-1:0] src_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept;

    // Qualify a start: idle, pipeline drained, legal opcode and count.
    always_comb begin
        accept = start && (state == ST_IDLE) && !pipe_busy &&
                 (cnt_in != '0) && (cnt_in <= DEPTH) &&
                 (mv_op_e'(op_in) != OP_RSVD);
    end

    // Final index of the sweep reached.
    always_comb begin
        last_word = ((CNT_W'(idx) + CNT_W'(1)) == cnt_q);
    end

    // State, index and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            op_q  <= OP_COPY_XY;
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_SRC_SLOT;
                        idx   <= '0;
                        op_q  <= mv_op_e'(op_in);
                        src_q <= src_in;
                        dst_q <= dst_in;
                        cnt_q <= cnt_in;
                    end
                end
                ST_SRC_SLOT: state <= ST_DST_SLOT;
                ST_DST_SLOT: begin
                    if (last_word) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_SRC_SLOT;
                        idx   <= idx + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read port: source word in its slot, destination word only if kept.
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = {src_q, idx};
        if (state == ST_SRC_SLOT) begin
            rd_en = 1'b1;
        end else if (state == ST_DST_SLOT) begin
            rd_addr = {dst_q, idx};
            rd_en   = (op_q != OP_COPY_XY);
        end
    end
endmodule

// File: rtl/pair_pipe.sv
// Write pipeline: holds the source word, pairs it with the destination word
// per lane (X, Y), and issues one joint write plus the done pulse.
// Assumes: read data arrives one cycle after the read enable; op and dst
// stay stable until the pipeline has drained.
module pair_pipe
    import mover_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4,
    parameter int BANK_W = 2,
    localparam int ADDR_W = BANK_W + IDX_W,
    localparam int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dst_slot,
    input  logic [IDX_W-1:0]  idx,
    input  logic              last_word,
    input  mv_op_e            op_q,
    input  logic [BANK_W-1:0] dst_q,
    input  logic [WORD_W-1:0] rd_x,
    input  logic [WORD_W-1:0] rd_y,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_x,
    output logic [WORD_W-1:0] wr_y,
    output logic              wr_en,
    output logic              done,
    output logic              active
);
    logic [WORD_W-1:0] rd_lane [LANES];
    logic [WORD_W-1:0] wr_lane [LANES];
    logic              pair_v;
    logic              pair_last;
    logic [IDX_W-1:0]  pair_idx;
    logic              wr_last;

    assign rd_lane[0] = rd_x;
    assign rd_lane[1] = rd_y;
    assign wr_x       = wr_lane[0];
    assign wr_y       = wr_lane[1];
    assign active     = pair_v | wr_en;

    // Per-word control: capture timing, write strobe, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_v    <= 1'b0;
            pair_last <= 1'b0;
            pair_idx  <= '0;
            wr_en     <= 1'b0;
            wr_last   <= 1'b0;
            wr_addr   <= '0;
            done      <= 1'b0;
        end else begin
            pair_v <= dst_slot;
            if (dst_slot) begin
                pair_idx  <= idx;
                pair_last <= last_word;
            end
            wr_en <= pair_v;
            if (pair_v) begin
                wr_addr <= {dst_q, pair_idx};
                wr_last <= pair_last;
            end
            done <= wr_en && wr_last;
        end
    end

    // One lane per sub-bank: keep the old word when this lane is not replaced.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [WORD_W-1:0] hold;
        logic              keep_old;

        // Lane 0 (X) is kept by the Y-only opcode, lane 1 (Y) by X-only.
        always_comb begin
            keep_old = (ln == 0) ? (op_q == OP_COPY_Y) : (op_q == OP_COPY_X);
        end

        // Register source word, then form the outgoing lane word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold        <= '0;
                wr_lane[ln] <= '0;
            end else begin
                if (dst_slot) hold <= rd_lane[ln];
                if (pair_v)   wr_lane[ln] <= keep_old ? rd_lane[ln] : hold;
            end
        end
    end
endmodule

// File: rtl/bank_sweep_mover.sv
// Top of the bank sweep mover: controller plus write pipeline.
// Assumes: single shared read port with one-cycle latency; X and Y of a
// bank are written only together through one enable.
module bank_sweep_mover
    import mover_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4,
    parameter int BANK_W = 2,
    localparam int CNT_W  = IDX_W + 1,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        opcode,
    input  logic [BANK_W-1:0] src_bank,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    input  logic [WORD_W-1:0] rd_x,
    input  logic [WORD_W-1:0] rd_y,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_x,
    output logic [WORD_W-1:0] wr_y,
    output logic              wr_en,
    output logic              busy,
    output logic              done
);
    mv_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic              last_word;
    mv_op_e            op_q;
    logic [BANK_W-1:0] dst_q;
    logic              pipe_active;

    sweep_ctrl #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_in     (opcode),
        .src_in    (src_bank),
        .dst_in    (dst_bank),
        .cnt_in    (word_cnt),
        .pipe_busy (pipe_active),
        .state     (state),
        .idx       (idx),
        .last_word (last_word),
        .op_q      (op_q),
        .dst_q     (dst_q),
        .rd_addr   (rd_addr),
        .rd_en     (rd_en)
    );

    pair_pipe #(.WORD_W(WORD_W), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .dst_slot  (state == ST_DST_SLOT),
        .idx       (idx),
        .last_word (last_word),
        .op_q      (op_q),
        .dst_q     (dst_q),
        .rd_x      (rd_x),
        .rd_y      (rd_y),
        .wr_addr   (wr_addr),
        .wr_x      (wr_x),
        .wr_y      (wr_y),
        .wr_en     (wr_en),
        .done      (done),
        .active    (pipe_active)
    );

    // Busy covers the sweep and the writes still in flight.
    always_comb begin
        busy = (state != ST_IDLE) || pipe_active;
    end
endmodule

// File: rtl/bank_sweep_mover_chk.sv
// Protocol checker for the bank sweep mover, bound to every instance.
// Assumes: rst_n is low at the first clock edge.
module bank_sweep_mover_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic rd_en,
    input logic wr_en,
    input logic busy,
    input logic done
);
    // Reset clears every strobe in the following cycle.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_en && !wr_en && !done && !busy));

    // Writes are spaced by the two-slot word cadence.
    assert_write_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // done lasts a single cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // done directly follows a write.
    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    // Activity starts only from a start request.
    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // Nothing is written once the block has gone idle.
    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (!wr_en && !rd_en));
endmodule

bind bank_sweep_mover bank_sweep_mover_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .busy  (busy),
    .done  (done)
);

// File: tb/tb_bank_sweep_mover.sv
module tb_bank_sweep_mover;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;
    localparam int BANK_W = 2;
    localparam int CNT_W  = IDX_W + 1;
    localparam int ADDR_W = BANK_W + IDX_W;
    localparam int LOCS   = 1 << ADDR_W;
    localparam int NVEC   = 7;
    // {opcode[10:9], src[8:7], dst[6:5], count[4:0]}
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 2'd1, 5'd16},
        {2'd1, 2'd2, 2'd3, 5'd5},
        {2'd2, 2'd1, 2'd0, 5'd1},
        {2'd0, 2'd3, 2'd2, 5'd7},
        {2'd1, 2'd0, 2'd0, 5'd3},
        {2'd2, 2'd3, 2'd1, 5'd16},
        {2'd1, 2'd1, 2'd2, 5'd16}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        opcode = '0;
    logic [BANK_W-1:0] src_bank = '0;
    logic [BANK_W-1:0] dst_bank = '0;
    logic [CNT_W-1:0]  word_cnt = '0;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              rd_en, wr_en, busy, done;
    logic [WORD_W-1:0] rd_x = '0, rd_y = '0, wr_x, wr_y;

    logic [WORD_W-1:0] mx [LOCS];
    logic [WORD_W-1:0] my [LOCS];
    logic [WORD_W-1:0] ex [LOCS];
    logic [WORD_W-1:0] ey [LOCS];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_sweep_mover #(.WORD_W(WORD_W), .IDX_W(IDX_W), .BANK_W(BANK_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src_bank(src_bank), .dst_bank(dst_bank), .word_cnt(word_cnt),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
        .wr_addr(wr_addr), .wr_x(wr_x), .wr_y(wr_y), .wr_en(wr_en),
        .busy(busy), .done(done)
    );

    // Memory model: one-cycle read latency, joint X/Y write.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_x <= mx[rd_addr];
            rd_y <= my[rd_addr];
        end
        if (wr_en) begin
            mx[wr_addr] <= wr_x;
            my[wr_addr] <= wr_y;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < LOCS; a++) begin
            mx[a] = WORD_W'(a * 37 + seed * 911 + 1);
            my[a] = WORD_W'(a * 53 + seed * 277) ^ 16'h5a5a;
        end
    endtask

    task automatic mem_compare(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < LOCS; a++) begin
            if (mx[a] !== ex[a] || my[a] !== ey[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s memory at %0d actual x=%h y=%h expected x=%h y=%h",
                     req, first, mx[first], my[first], ex[first], ey[first]);
        end
    endtask

    // Run one sweep; optionally raise a second start mid-sweep (R8).
    task automatic run_job(input logic [1:0] op, input logic [1:0] sb,
                           input logic [1:0] db, input int n, input bit poke);
        logic [WORD_W-1:0] px [LOCS];
        logic [WORD_W-1:0] py [LOCS];
        string rq;
        int reads = 0, writes = 0, dones = 0, done_k = -1, addr_bad = 0;
        rq = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : "R4";
        for (int a = 0; a < LOCS; a++) begin
            px[a] = mx[a]; py[a] = my[a];
            ex[a] = mx[a]; ey[a] = my[a];
        end
        for (int i = 0; i < n; i++) begin
            int s = sb * 16 + i;
            int d = db * 16 + i;
            ex[d] = (op == 2'd2) ? px[d] : px[s];
            ey[d] = (op == 2'd1) ? py[d] : py[s];
        end
        opcode = op; src_bank = sb; dst_bank = db; word_cnt = CNT_W'(n);
        start = 1'b1;
        for (int k = 1; k <= 2 * n + 12; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 3) begin
                start = 1'b1; opcode = 2'd0; src_bank = db; dst_bank = sb;
                word_cnt = 5'd2;
            end
            if (poke && k == 4) start = 1'b0;
            if (rd_en) reads++;
            if (wr_en) begin
                if (wr_addr !== ADDR_W'(db * 16 + writes)) addr_bad++;
                writes++;
            end
            if (done) begin
                dones++;
                done_k = k;
            end
        end
        mem_compare(poke ? "R8" : rq);
        check(addr_bad == 0, "R6 write address order", addr_bad, 0);
        check(writes == n, "R6 write count", writes, n);
        check(reads == ((op == 2'd0) ? n : 2 * n), "R5 read count", reads,
              (op == 2'd0) ? n : 2 * n);
        check(dones == 1, "R7 done pulses", dones, 1);
        check(done_k == 2 * n + 3, "R7 done cycle", done_k, 2 * n + 3);
    endtask

    // Start that must be rejected (R9).
    task automatic reject(input logic [1:0] op, input int n);
        int act = 0;
        for (int a = 0; a < LOCS; a++) begin
            ex[a] = mx[a]; ey[a] = my[a];
        end
        opcode = op; src_bank = 2'd0; dst_bank = 2'd1; word_cnt = CNT_W'(n);
        start = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (rd_en || wr_en || done || busy) act++;
        end
        check(act == 0, "R9 rejected start activity", act, 0);
        mem_compare("R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        check(!rd_en && !wr_en && !done && !busy, "R1 reset outputs",
              int'({rd_en, wr_en, done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            fill(v + 1);
            run_job(VEC[v][10:9], VEC[v][8:7], VEC[v][6:5], int'(VEC[v][4:0]), 1'b0);
        end

        // R8: start while busy is ignored
        fill(20);
        run_job(2'd1, 2'd2, 2'd0, 6, 1'b1);

        // R9: zero count, too large a count, reserved opcode
        fill(21);
        reject(2'd0, 0);
        reject(2'd1, 17);
        reject(2'd3, 4);

        // R1: reset in the middle of a sweep stops it
        fill(22);
        opcode = 2'd0; src_bank = 2'd0; dst_bank = 2'd3; word_cnt = 5'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!rd_en && !wr_en && !done && !busy, "R1 mid-sweep reset",
              int'({rd_en, wr_en, done, busy}), 0);
        rst_n = 1'b1;
        begin
            int act = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (wr_en || done) act++;
            end
            check(act == 0, "R1 no activity after reset", act, 0);
        end

        // Block is usable again after the reset
        fill(23);
        run_job(2'd2, 2'd0, 2'd3, 16, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule